// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus master that walks a ring of transmit descriptors kept in system memory. Each descriptor is four 32-bit words: a control word that holds the ownership flag and the per-frame options, the address of the frame buffer, a word with the byte count and the completion status, and the address of the next descriptor. Software fills a descriptor, hands it to the engine by setting the ownership flag, and then writes the demand register. The engine fetches the descriptor and passes the buffer address, the length and the options to a transmit datapath. It waits for that datapath to report done. It then writes back the status, hands ownership back to software, and moves on to the next descriptor.

The walk continues from descriptor to descriptor for as long as the engine owns each one it reads. It halts on the first descriptor that belongs to software and keeps that descriptor as the current one, so that the next demand write tries it again. Frame data movement and MAC framing are done elsewhere. This block only sequences descriptors and keeps the small set of pointers and flags that software reads back.

Top module: `txring_engine`

## Requirements
- R1: A descriptor at address D is fetched as four word reads in the order D, D+4, D+8, D+12 (control, buffer address, length/status, next pointer). Every memory request stays asserted, with a stable address and direction, until it is acknowledged.
- R2: If bit 31 of the control word is 0, the descriptor belongs to software. The engine then reads only that word, starts no frame, returns to idle and keeps D as the current descriptor.
- R3: A write to register 2, with any data, leaves a demand pending. The engine takes the demand when it is idle with transmit enabled: it re-reads the current descriptor and resumes if it owns it. A demand that arrives while transmit is disabled is held until transmit is enabled.
- R4: For an engine-owned descriptor, `tx_start` pulses for exactly one cycle. While it pulses, no memory request is active, `tx_buf_addr` holds word D+4, `tx_len` holds bits 15:0 of word D+8, `tx_pad` holds control bit 0 and `tx_crc` holds control bit 1.
- R5: After `tx_done`, the engine writes word D+8 back with bit 19 set and every other bit unchanged. It then writes word D with bit 31 cleared and every other bit unchanged. The status write always comes before the control write, and the engine writes no other address.
- R6: Once the control write is done, the current descriptor becomes the next pointer read from D+12. A ring whose last next pointer leads back to its first descriptor (a one-entry ring that points to itself included) wraps around.
- R7: A new descriptor fetch starts only while bit 8 of register 0 (transmit enable) is 1. With the bit at 0, a demand causes no memory traffic at all.
- R8: When a descriptor whose control bit 2 is 1 completes, bit 0 of register 5 and the `irq` output are set. Writing a 1 to bit 0 of register 5 clears them. A descriptor with control bit 2 at 0 leaves them unchanged.
- R9: Register 3 reads the current descriptor address and register 4 reads the buffer address fetched last. A write to register 1 is read back from register 1, and while the engine is idle it also loads the current descriptor address.
- R10: After reset, registers 3, 4 and 5 read 0, and `irq`, `tx_start` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_start | output | 1 | One-cycle frame start toward the datapath |
| tx_buf_addr | output | 32 | Frame buffer address |
| tx_len | output | 16 | Frame byte count |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Datapath finished the frame |
| irq | output | 1 | Transmit interrupt flag |

## Verification
Reset is released through a two-stage synchronizer, so outputs are checked a few cycles after `rst_n` rises. A register read is valid in the same cycle its index is applied, and the bench samples it 1 ns after the falling edge. Each memory word takes two cycles, a request cycle and an acknowledge cycle. `tx_start` comes in the cycle after the acknowledge of the next-pointer read. The interrupt flag is set in the cycle after the control write-back is acknowledged. The bench therefore compares every `tx_start` against its expected frame queue on every falling edge. It checks the logged memory traffic, the memory image and the registers only after the walk has gone quiet.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_MODE, ST_RD_BUF, ST_RD_LEN, ST_RD_NEXT,
    ST_START, ST_WAIT, ST_WR_STAT, ST_WR_MODE
  } walk_st_e;

  localparam int OWN_BIT  = 31;
  localparam int PAD_BIT  = 0;
  localparam int CRC_BIT  = 1;
  localparam int IRQ_BIT  = 2;
  localparam int DONE_BIT = 19;
  localparam int EN_BIT   = 8;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_KICK = 3'd2;
  localparam logic [2:0] RA_CUR  = 3'd3;
  localparam logic [2:0] RA_BUF  = 3'd4;
  localparam logic [2:0] RA_INT  = 3'd5;
endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] cur_desc,
  input  logic [AW-1:0] cur_buf,
  input  logic          int_set,
  input  logic          kick_take,
  output logic          tx_en,
  output logic          base_load,
  output logic          kick_pend,
  output logic          irq
);
  logic          en_q, en_d;
  logic [AW-1:0] base_q, base_d;
  logic          int_q, int_d;
  logic          pend_q, pend_d;
  logic          wr_ctrl, wr_base, wr_kick, wr_int;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_base = reg_wr && (reg_addr == RA_BASE);
  assign wr_kick = reg_wr && (reg_addr == RA_KICK);
  assign wr_int  = reg_wr && (reg_addr == RA_INT);

  always_comb begin
    en_d   = en_q;
    base_d = base_q;
    int_d  = int_q;
    pend_d = pend_q;
    if (wr_ctrl) en_d = reg_wdata[EN_BIT];
    if (wr_base) base_d = reg_wdata[AW-1:0];
    if (wr_int && reg_wdata[0]) int_d = 1'b0;
    if (int_set) int_d = 1'b1;
    if (kick_take) pend_d = 1'b0;
    if (wr_kick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      int_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
      int_q  <= int_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: reg_rdata = 32'(en_q) << EN_BIT;
      RA_BASE: reg_rdata = 32'(base_q);
      RA_CUR:  reg_rdata = 32'(cur_desc);
      RA_BUF:  reg_rdata = 32'(cur_buf);
      RA_INT:  reg_rdata = 32'(int_q);
      default: reg_rdata = '0;
    endcase
  end

  assign tx_en     = en_q;
  assign base_load = wr_base;
  assign kick_pend = pend_q;
  assign irq       = int_q;
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             kick_pend,
  output logic             kick_take,
  input  logic             base_load,
  input  logic [AW-1:0]    base_val,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_start,
  output logic [AW-1:0]    tx_buf_addr,
  output logic [LEN_W-1:0] tx_len,
  output logic             tx_pad,
  output logic             tx_crc,
  input  logic             tx_done,
  output logic [AW-1:0]    cur_desc,
  output logic [AW-1:0]    cur_buf,
  output logic             int_set
);
  localparam logic [AW-1:0] OFS_BUF  = AW'(4);
  localparam logic [AW-1:0] OFS_LEN  = AW'(8);
  localparam logic [AW-1:0] OFS_NEXT = AW'(12);

  walk_st_e      state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] buf_q, buf_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic [31:0]   mode_q, mode_d;
  logic [31:0]   sl_q, sl_d;

  // next-state process
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    buf_d     = buf_q;
    nxt_d     = nxt_q;
    mode_d    = mode_q;
    sl_d      = sl_q;
    kick_take = 1'b0;
    int_set   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (base_load) cur_d = base_val;
        if (kick_pend && tx_en) begin
          kick_take = 1'b1;
          state_d   = ST_RD_MODE;
        end
      end
      ST_RD_MODE: if (mem_ack) begin
        mode_d  = mem_rdata;
        state_d = mem_rdata[OWN_BIT] ? ST_RD_BUF : ST_IDLE;
      end
      ST_RD_BUF: if (mem_ack) begin
        buf_d   = mem_rdata[AW-1:0];
        state_d = ST_RD_LEN;
      end
      ST_RD_LEN: if (mem_ack) begin
        sl_d    = mem_rdata;
        state_d = ST_RD_NEXT;
      end
      ST_RD_NEXT: if (mem_ack) begin
        nxt_d   = mem_rdata[AW-1:0];
        state_d = ST_START;
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (tx_done) state_d = ST_WR_STAT;
      ST_WR_STAT: if (mem_ack) state_d = ST_WR_MODE;
      ST_WR_MODE: if (mem_ack) begin
        cur_d   = nxt_q;
        int_set = mode_q[IRQ_BIT];
        if (tx_en) begin
          kick_take = kick_pend;
          state_d   = ST_RD_MODE;
        end else begin
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      mode_q  <= '0;
      sl_q    <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      buf_q   <= buf_d;
      nxt_q   <= nxt_d;
      mode_q  <= mode_d;
      sl_q    <= sl_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD_MODE: mem_addr = cur_q;
      ST_RD_BUF:  mem_addr = cur_q + OFS_BUF;
      ST_RD_LEN:  mem_addr = cur_q + OFS_LEN;
      ST_RD_NEXT: mem_addr = cur_q + OFS_NEXT;
      ST_WR_STAT: begin
        mem_we    = 1'b1;
        mem_addr  = cur_q + OFS_LEN;
        mem_wdata = sl_q | (32'd1 << DONE_BIT);
      end
      ST_WR_MODE: begin
        mem_we    = 1'b1;
        mem_addr  = cur_q;
        mem_wdata = mode_q & ~(32'd1 << OWN_BIT);
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign tx_start    = (state_q == ST_START);
  assign tx_buf_addr = buf_q;
  assign tx_len      = sl_q[LEN_W-1:0];
  assign tx_pad      = mode_q[PAD_BIT];
  assign tx_crc      = mode_q[CRC_BIT];
  assign cur_desc    = cur_q;
  assign cur_buf     = buf_q;
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_start,
  output logic [AW-1:0]    tx_buf_addr,
  output logic [LEN_W-1:0] tx_len,
  output logic             tx_pad,
  output logic             tx_crc,
  input  logic             tx_done,
  output logic             irq
);
  logic          srst_n;
  logic          tx_en, kick_pend, kick_take, base_load, int_set;
  logic [AW-1:0] cur_desc, cur_buf;

  txr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  txr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cur_desc(cur_desc), .cur_buf(cur_buf),
    .int_set(int_set), .kick_take(kick_take),
    .tx_en(tx_en), .base_load(base_load), .kick_pend(kick_pend), .irq(irq)
  );

  txr_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(srst_n),
    .tx_en(tx_en), .kick_pend(kick_pend), .kick_take(kick_take),
    .base_load(base_load), .base_val(reg_wdata[AW-1:0]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_start(tx_start), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done),
    .cur_desc(cur_desc), .cur_buf(cur_buf), .int_set(int_set)
  );
endmodule

// File: rtl/txr_checks.sv
module txr_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          tx_start,
  input logic          irq,
  input logic [AW-1:0] cur_desc
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R4

  AST_START_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !mem_req); // R4

  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_addr == cur_desc) || (mem_addr == cur_desc + AW'(8))); // R5

  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req && mem_we && mem_ack)); // R8
endmodule

bind txring_engine txr_checks #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(srst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .tx_start(tx_start),
  .irq(irq), .cur_desc(cur_desc)
);

// File: tb/txring_engine_tb.sv
`timescale 1ns/1ps
module txring_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_start, tx_pad, tx_crc, tx_done, irq;
  logic [31:0] tx_buf_addr;
  logic [15:0] tx_len;

  always #4 clk = ~clk;

  txring_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_start(tx_start), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model with a back door for setup
  logic [31:0] mem [0:255];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  int unsigned rlog[$];
  int unsigned wlog[$];

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr[9:2]] <= bd_data;
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wlog.push_back(mem_addr);
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        rlog.push_back(mem_addr);
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // transmit datapath model
  int dcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      dcnt    <= 0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= (dcnt == 1);
      if (tx_start)       dcnt <= 4;
      else if (dcnt != 0) dcnt <= dcnt - 1;
    end
  end

  // reference model: expected frame queue {addr, len, pad, crc}, compared each clock
  logic [49:0] expq[$];
  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      if (expq.size() == 0) begin
        chk("R4 unexpected tx_start", 64'(tx_start), 64'd0);
      end else begin
        chk("R4 frame fields", 64'({tx_buf_addr, tx_len, tx_pad, tx_crc}), 64'(expq[0]));
        void'(expq.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic settle();
    for (int i = 0; i < 1000 && expq.size() != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_log(string tag, int unsigned lg[$], int unsigned ex[$]);
    chk({tag, " count"}, 64'(lg.size()), 64'(ex.size()));
    for (int i = 0; i < ex.size() && i < lg.size(); i++)
      chk(tag, 64'(lg[i]), 64'(ex[i]));
  endtask

  logic [31:0] v;
  int n0;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(3'd3, v); chk("R10 cur desc", 64'(v), 64'd0);
    rd(3'd4, v); chk("R10 cur buf", 64'(v), 64'd0);
    rd(3'd5, v); chk("R10 int stat", 64'(v), 64'd0);
    chk("R10 outputs", 64'({irq, tx_start, mem_req}), 64'd0);

    // ring of three: two owned, third software-owned
    put(32'h100, 32'h8000_0007); put(32'h104, 32'h200);
    put(32'h108, 32'h00A3_0040); put(32'h10C, 32'h110);
    put(32'h110, 32'h8000_0002); put(32'h114, 32'h280);
    put(32'h118, 32'h0000_05EE); put(32'h11C, 32'h120);
    put(32'h120, 32'h0000_0003); put(32'h124, 32'h300);
    put(32'h128, 32'h0000_003C); put(32'h12C, 32'h100);
    rlog.delete(); wlog.delete();
    expq.push_back({32'h200, 16'h0040, 1'b1, 1'b1});  // R4 length from low 16 bits only
    expq.push_back({32'h280, 16'h05EE, 1'b0, 1'b1});
    wr(3'd1, 32'h100);
    rd(3'd1, v); chk("R9 base readback", 64'(v), 64'h100);
    rd(3'd3, v); chk("R9 base loads current", 64'(v), 64'h100);
    wr(3'd0, 32'h100);
    wr(3'd2, 32'h0);
    settle();
    chk("R4 all frames sent", 64'(expq.size()), 64'd0);
    chk_log("R1 fetch order", rlog, '{32'h100, 32'h104, 32'h108, 32'h10C,
                                      32'h110, 32'h114, 32'h118, 32'h11C, 32'h120});
    chk_log("R5 write order", wlog, '{32'h108, 32'h100, 32'h118, 32'h110});
    chk("R5 status d0", 64'(mem[8'h42]), 64'h00AB_0040);
    chk("R5 mode d0", 64'(mem[8'h40]), 64'h0000_0007);
    chk("R5 status d1", 64'(mem[8'h46]), 64'h0008_05EE);
    chk("R5 mode d1", 64'(mem[8'h44]), 64'h0000_0002);
    rd(3'd3, v); chk("R2 halt on software-owned", 64'(v), 64'h120);
    rd(3'd4, v); chk("R9 cur buf", 64'(v), 64'h280);
    rd(3'd5, v); chk("R8 int set by d0", 64'(v), 64'd1);
    chk("R8 irq pin", 64'(irq), 64'd1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R8 int cleared", 64'(v), 64'd0);
    chk("R8 irq pin cleared", 64'(irq), 64'd0);

    // R7: demand with transmit disabled, then R3 held demand fires on enable
    wr(3'd0, 32'h0);
    put(32'h120, 32'h8000_0003);
    rlog.delete(); wlog.delete();
    wr(3'd2, 32'h5A5A);
    repeat (40) @(negedge clk);
    chk("R7 no fetch while disabled", 64'(rlog.size() + wlog.size()), 64'd0);
    rd(3'd3, v); chk("R7 current kept", 64'(v), 64'h120);
    expq.push_back({32'h300, 16'h003C, 1'b1, 1'b1});
    wr(3'd0, 32'h100);
    settle();
    chk("R3 held demand served", 64'(expq.size()), 64'd0);
    chk_log("R6 wrap fetch", rlog, '{32'h120, 32'h124, 32'h128, 32'h12C, 32'h100});
    chk_log("R5 write d2", wlog, '{32'h128, 32'h120});
    chk("R5 status d2", 64'(mem[8'h4A]), 64'h0008_003C);
    chk("R5 mode d2", 64'(mem[8'h48]), 64'h0000_0003);
    rd(3'd3, v); chk("R6 wrapped to first", 64'(v), 64'h100);
    rd(3'd5, v); chk("R8 no int without enable bit", 64'(v), 64'd0);

    // R2/R3: demand on a software-owned descriptor
    rlog.delete(); wlog.delete();
    wr(3'd2, 32'h0);
    repeat (40) @(negedge clk);
    chk_log("R2 single read", rlog, '{32'h100});
    chk("R2 no writes", 64'(wlog.size()), 64'd0);
    rd(3'd3, v); chk("R2 current unchanged", 64'(v), 64'h100);

    // R6/R9: relocated one-entry ring pointing to itself
    put(32'h180, 32'h8000_0004); put(32'h184, 32'h3C0);
    put(32'h188, 32'h0000_0001); put(32'h18C, 32'h180);
    rlog.delete(); wlog.delete();
    expq.push_back({32'h3C0, 16'h0001, 1'b0, 1'b0});
    wr(3'd1, 32'h180);
    wr(3'd2, 32'h0);
    settle();
    chk("R4 self ring frame", 64'(expq.size()), 64'd0);
    chk_log("R6 self loop fetch", rlog, '{32'h180, 32'h184, 32'h188, 32'h18C, 32'h180});
    chk("R5 status self", 64'(mem[8'h62]), 64'h0008_0001);
    chk("R5 mode self", 64'(mem[8'h60]), 64'h0000_0004);
    rd(3'd3, v); chk("R9 current self", 64'(v), 64'h180);
    rd(3'd4, v); chk("R9 buf self", 64'(v), 64'h3C0);
    rd(3'd5, v); chk("R8 int self", 64'(v), 64'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule